// File: doc/BRIEF.md
# Management Data Command Engine with PHY Register Responder

This block is the management side of an Ethernet MAC as seen from the host. The host sets an enable bit and a clock divider in a configuration register and loads a 16-bit transmit-data register. It then writes a control word that names a PHY address, a register address and an operation. A valid write operation copies the transmit data into the addressed PHY register. A valid read operation loads the PHY register into a read-data register. Each completed access sets a completion flag in a status register. The host clears that flag by writing a one to it.

The PHY side is a register responder that answers at one parameterised address. It holds 32 registers of 16 bits, and four of them have reset values set by parameters. Three registers are not plain storage: the basic status register, the link-partner register and the resolved speed/duplex register. The responder builds their values from fixed capability bits and from whatever the host has written into the advertisement register (register 4). Only the register-level exchange is modelled. The serial bit waveform on the management pins is not part of this block.

Top module: `mgmt_cmd_engine`

## Requirements
- R1: After reset, PHY registers 0, 2, 3 and 4 read as 0x3100, 0x0300, 0xE400 and 0x01E1.
- R2: Host register index 1 is the control word. Its fields are: bits 28:24 the PHY address, bits 20:16 the register address, bits 15:14 the operation, and bit 11 the initiate flag. Operation 1 writes bits 15:0 of the transmit-data register (index 2) into the addressed PHY register.
- R3: Operation 2 loads the addressed PHY register into the read-data register (index 3). The read-data register reads with bits 31:16 at zero. The new value is readable from the second clock edge after the control write.
- R4: An initiated access with operation code 0 or 3 makes no PHY access and leaves the read-data register unchanged. It sets the invalid-operation flag, status bit 1.
- R5: The configuration register is index 0. Bit 6 is the enable and bits 5:0 are the divider. An initiate while the enable is clear does nothing. An initiate while enabled with a zero divider makes no access and sets the divider-error flag, status bit 2.
- R6: A read of the control word returns the value last written to it, with bit 7 always reading as one.
- R7: The PHY address is 5 bits wide. A write to an address other than the responder's changes no responder register. A read from such an address loads 0xFFFF into the read-data register.
- R8: PHY register 1 always reads as 0x782E, whatever has been written to it.
- R9: PHY register 5 reads as 0x4000 ORed with bits 8:5 of the advertisement register.
- R10: The speed/duplex register reads with bit 10 set when advertisement bit 7 or bit 8 is set, and with bit 11 set when advertisement bit 8 or bit 6 is set. All its other bits read as zero. It sits at register 18 by default.
- R11: The status register is index 4. Bit 0 sets when a valid access completes. Writing a one to any status bit clears it. Status reads as zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 3 | Host register index, used for both reads and writes |
| host_wdata | input | HOST_DW | Host write data |
| host_rdata | output | HOST_DW | Read data for host_addr (combinational) |

## Verification
The bench builds the engine with the responder at PHY address 21, not the default 7. Address 7 then works as a foreign address, which exercises the address compare in both directions. All other parameters keep their defaults, so the speed/duplex register is at 18 and absent PHYs read as all ones. Random advertisement words show that the derived registers depend only on bits 8:5. Directed single-bit words cover each half/full and 10/100 combination.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

   localparam int unsigned HOST_IDX_W = 3;
   localparam int unsigned PHY_DW     = 16;
   localparam int unsigned PHYA_W     = 5;
   localparam int unsigned REGA_W     = 5;
   localparam int unsigned NUM_PREGS  = 1 << REGA_W;

   // control word field positions
   localparam int unsigned F_PHY_LSB  = 24;
   localparam int unsigned F_REG_LSB  = 16;
   localparam int unsigned F_OP_LSB   = 14;
   localparam int unsigned F_GO_BIT   = 11;
   localparam int unsigned F_RDY_BIT  = 7;

   // configuration register fields
   localparam int unsigned CFG_EN_BIT = 6;
   localparam int unsigned CFG_DIV_W  = 6;
   localparam int unsigned CFG_W      = CFG_EN_BIT + 1;

   // status bits
   localparam int unsigned ST_DONE    = 0;
   localparam int unsigned ST_BADOP   = 1;
   localparam int unsigned ST_DIVERR  = 2;
   localparam int unsigned ST_W       = 3;

   typedef enum logic [HOST_IDX_W-1:0] {
      HR_CFG  = 3'd0,
      HR_CTRL = 3'd1,
      HR_TXD  = 3'd2,
      HR_RXD  = 3'd3,
      HR_STAT = 3'd4
   } host_reg_e;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_WR   = 2'd1,
      OP_RD   = 2'd2,
      OP_RSVD = 2'd3
   } mgmt_op_e;

   typedef struct packed {
      logic              valid;
      logic              wr;
      logic [PHYA_W-1:0] phy;
      logic [REGA_W-1:0] regn;
      logic [PHY_DW-1:0] data;
   } phy_req_t;

endpackage

// File: rtl/mgmt_host_regs.sv
module mgmt_host_regs
   import mgmt_pkg::*;
#(
   parameter int unsigned HOST_DW = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_wr,
   input  logic [HOST_IDX_W-1:0] host_addr,
   input  logic [HOST_DW-1:0]    host_wdata,
   output logic [HOST_DW-1:0]    host_rdata,
   input  logic [PHY_DW-1:0]     rx_data,
   input  logic [ST_W-1:0]       status,
   output logic                  cfg_en,
   output logic [CFG_DIV_W-1:0]  cfg_div,
   output logic                  go,
   output logic [1:0]            go_op,
   output logic [PHYA_W-1:0]     go_phy,
   output logic [REGA_W-1:0]     go_reg,
   output logic [PHY_DW-1:0]     tx_data,
   output logic [ST_W-1:0]       stat_clr
);

   logic [CFG_W-1:0]   cfg_q;
   logic [31:0]        ctrl_q;
   logic [PHY_DW-1:0]  txd_q;
   logic               wr_cfg, wr_ctrl, wr_txd, wr_stat;

   assign wr_cfg  = host_wr && (host_addr == HR_CFG);
   assign wr_ctrl = host_wr && (host_addr == HR_CTRL);
   assign wr_txd  = host_wr && (host_addr == HR_TXD);
   assign wr_stat = host_wr && (host_addr == HR_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         ctrl_q <= '0;
         txd_q  <= '0;
      end else begin
         if (wr_cfg)  cfg_q  <= host_wdata[CFG_W-1:0];
         if (wr_ctrl) ctrl_q <= host_wdata[31:0];
         if (wr_txd)  txd_q  <= host_wdata[PHY_DW-1:0];
      end
   end

   assign cfg_en   = cfg_q[CFG_EN_BIT];
   assign cfg_div  = cfg_q[CFG_DIV_W-1:0];
   assign tx_data  = txd_q;
   assign stat_clr = wr_stat ? host_wdata[ST_W-1:0] : '0;

   // command fields are taken straight from the write data
   assign go     = wr_ctrl && host_wdata[F_GO_BIT];
   assign go_op  = host_wdata[F_OP_LSB +: 2];
   assign go_phy = host_wdata[F_PHY_LSB +: PHYA_W];
   assign go_reg = host_wdata[F_REG_LSB +: REGA_W];

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         HR_CFG:  host_rdata[CFG_W-1:0] = cfg_q;
         HR_CTRL: begin
            host_rdata[31:0]      = ctrl_q;
            host_rdata[F_RDY_BIT] = 1'b1;
         end
         HR_TXD:  host_rdata[PHY_DW-1:0] = txd_q;
         HR_RXD:  host_rdata[PHY_DW-1:0] = rx_data;
         HR_STAT: host_rdata[ST_W-1:0]   = status;
         default: host_rdata = '0;
      endcase
   end

endmodule

// File: rtl/mgmt_access_seq.sv
module mgmt_access_seq
   import mgmt_pkg::*;
#(
   parameter bit NOPHY_ONES = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go,
   input  logic [1:0]           go_op,
   input  logic [PHYA_W-1:0]    go_phy,
   input  logic [REGA_W-1:0]    go_reg,
   input  logic [PHY_DW-1:0]    tx_data,
   input  logic                 cfg_en,
   input  logic [CFG_DIV_W-1:0] cfg_div,
   input  logic [ST_W-1:0]      stat_clr,
   input  logic                 resp_hit,
   input  logic [PHY_DW-1:0]    resp_data,
   output phy_req_t             req,
   output logic [PHY_DW-1:0]    rx_data,
   output logic [ST_W-1:0]      status
);

   phy_req_t          req_q, req_n;
   logic [ST_W-1:0]   st_q, st_n;
   logic [PHY_DW-1:0] rx_q, fill;
   logic              fire, op_ok;

   // value seen when no PHY answers: pulled-up bus or zero
   generate
      if (NOPHY_ONES) begin : g_fill_ones
         assign fill = '1;
      end else begin : g_fill_zero
         assign fill = '0;
      end
   endgenerate

   assign fire  = go && cfg_en;
   assign op_ok = (go_op == OP_WR) || (go_op == OP_RD);

   always_comb begin
      st_n  = st_q & ~stat_clr;
      req_n = '0;
      if (req_q.valid) st_n[ST_DONE] = 1'b1;
      if (fire) begin
         if (cfg_div == '0) begin
            st_n[ST_DIVERR] = 1'b1;
         end else if (op_ok) begin
            req_n.valid = 1'b1;
            req_n.wr    = (go_op == OP_WR);
            req_n.phy   = go_phy;
            req_n.regn  = go_reg;
            req_n.data  = tx_data;
         end else begin
            st_n[ST_BADOP] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= '0;
         st_q  <= '0;
         rx_q  <= '0;
      end else begin
         req_q <= req_n;
         st_q  <= st_n;
         if (req_q.valid && !req_q.wr) rx_q <= resp_hit ? resp_data : fill;
      end
   end

   assign req     = req_q;
   assign rx_data = rx_q;
   assign status  = st_q;

   p_done_after_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_q.valid |=> status[ST_DONE]);

   p_bad_op_no_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (go && cfg_en && cfg_div != '0 && !(go_op == OP_WR || go_op == OP_RD))
      |=> (!req.valid && status[ST_BADOP]));

   p_zero_div_no_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (go && cfg_en && cfg_div == '0) |=> (!req.valid && status[ST_DIVERR]));

   p_disabled_no_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !cfg_en) |=> !req.valid);

   p_write_keeps_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req.valid && req.wr) |=> $stable(rx_data));

endmodule

// File: rtl/phy_reg_responder.sv
module phy_reg_responder
   import mgmt_pkg::*;
#(
   parameter int unsigned      PHY_ADDR  = 7,
   parameter int unsigned      SPEED_REG = 18,
   parameter logic [PHY_DW-1:0] RST_CTL  = 16'h3100,
   parameter logic [PHY_DW-1:0] RST_ID1  = 16'h0300,
   parameter logic [PHY_DW-1:0] RST_ID2  = 16'hE400,
   parameter logic [PHY_DW-1:0] RST_ADV  = 16'h01E1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phy_req_t          req,
   output logic              resp_hit,
   output logic [PHY_DW-1:0] resp_data
);

   localparam int unsigned   IDX_ADV  = 4;
   localparam int unsigned   IDX_BSR  = 1;
   localparam int unsigned   IDX_LPA  = 5;
   // speeds 13/14, modes 11/12, autoneg done 5, autoneg able 3, link 2/1
   localparam logic [PHY_DW-1:0] BSR_VAL  = 16'h782E;
   localparam logic [PHY_DW-1:0] LPA_BASE = 16'h4000;
   localparam logic [PHY_DW-1:0] ADV_MASK = 16'h01E0;
   localparam int unsigned   ADV_10F  = 6;
   localparam int unsigned   ADV_100H = 7;
   localparam int unsigned   ADV_100F = 8;
   localparam int unsigned   SPD_BIT  = 10;
   localparam int unsigned   DUP_BIT  = 11;

   generate
      if (PHY_ADDR >= (1 << PHYA_W)) begin : g_bad_addr
         $error("PHY_ADDR does not fit the address field");
      end
      if (SPEED_REG >= NUM_PREGS || SPEED_REG == IDX_BSR || SPEED_REG == IDX_LPA) begin : g_bad_spd
         $error("SPEED_REG collides with a fixed register or is out of range");
      end
   endgenerate

   function automatic logic [PHY_DW-1:0] reset_val(input int unsigned idx);
      case (idx)
         0:       return RST_CTL;
         2:       return RST_ID1;
         3:       return RST_ID2;
         4:       return RST_ADV;
         default: return '0;
      endcase
   endfunction

   logic [PHY_DW-1:0] mem_q [NUM_PREGS];
   logic [PHY_DW-1:0] adv, spd_word;
   logic              wr_hit;

   assign resp_hit = (req.phy == PHY_ADDR[PHYA_W-1:0]);
   assign wr_hit   = req.valid && req.wr && resp_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_PREGS; i++) mem_q[i] <= reset_val(i);
      end else if (wr_hit) begin
         mem_q[req.regn] <= req.data;
      end
   end

   assign adv = mem_q[IDX_ADV];

   always_comb begin
      spd_word          = '0;
      spd_word[SPD_BIT] = adv[ADV_100H] | adv[ADV_100F];
      spd_word[DUP_BIT] = adv[ADV_100F] | adv[ADV_10F];
   end

   always_comb begin
      if (req.regn == REGA_W'(IDX_BSR))        resp_data = BSR_VAL;
      else if (req.regn == REGA_W'(IDX_LPA))   resp_data = LPA_BASE | (adv & ADV_MASK);
      else if (req.regn == REGA_W'(SPEED_REG)) resp_data = spd_word;
      else                                     resp_data = mem_q[req.regn];
   end

   p_foreign_write_keeps_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req.valid && req.wr && req.phy != PHY_ADDR[PHYA_W-1:0]) |=> $stable(adv));

   p_read_keeps_adv_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req.valid && !req.wr) |=> $stable(adv));

endmodule

// File: rtl/mgmt_cmd_engine.sv
module mgmt_cmd_engine
   import mgmt_pkg::*;
#(
   parameter int unsigned HOST_DW    = 32,
   parameter int unsigned PHY_ADDR   = 7,
   parameter int unsigned SPEED_REG  = 18,
   parameter bit          NOPHY_ONES = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr,
   input  logic [2:0]         host_addr,
   input  logic [HOST_DW-1:0] host_wdata,
   output logic [HOST_DW-1:0] host_rdata
);

   generate
      if (HOST_DW < 32) begin : g_bad_dw
         $error("HOST_DW must hold the 32-bit control word");
      end
   endgenerate

   logic                 cfg_en, go;
   logic [CFG_DIV_W-1:0] cfg_div;
   logic [1:0]           go_op;
   logic [PHYA_W-1:0]    go_phy;
   logic [REGA_W-1:0]    go_reg;
   logic [PHY_DW-1:0]    tx_data, rx_data, resp_data;
   logic [ST_W-1:0]      status, stat_clr;
   logic                 resp_hit;
   phy_req_t             req;

   mgmt_host_regs #(.HOST_DW(HOST_DW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .rx_data    (rx_data),
      .status     (status),
      .cfg_en     (cfg_en),
      .cfg_div    (cfg_div),
      .go         (go),
      .go_op      (go_op),
      .go_phy     (go_phy),
      .go_reg     (go_reg),
      .tx_data    (tx_data),
      .stat_clr   (stat_clr)
   );

   mgmt_access_seq #(.NOPHY_ONES(NOPHY_ONES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .go_op     (go_op),
      .go_phy    (go_phy),
      .go_reg    (go_reg),
      .tx_data   (tx_data),
      .cfg_en    (cfg_en),
      .cfg_div   (cfg_div),
      .stat_clr  (stat_clr),
      .resp_hit  (resp_hit),
      .resp_data (resp_data),
      .req       (req),
      .rx_data   (rx_data),
      .status    (status)
   );

   phy_reg_responder #(.PHY_ADDR(PHY_ADDR), .SPEED_REG(SPEED_REG)) u_phy (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .resp_hit  (resp_hit),
      .resp_data (resp_data)
   );

   p_ctrl_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == HR_CTRL) |-> host_rdata[F_RDY_BIT]);

   p_rxd_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == HR_RXD) |-> (host_rdata[31:16] == '0));

endmodule

// File: tb/mgmt_cmd_engine_test.sv
module mgmt_cmd_engine_test;

   localparam int unsigned BPHY  = 21;
   localparam int unsigned OTHER = 7;
   localparam int unsigned SPD   = 18;
   localparam logic [2:0] A_CFG = 3'd0, A_CTRL = 3'd1, A_TXD = 3'd2, A_RXD = 3'd3, A_STAT = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [2:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   mgmt_cmd_engine #(.PHY_ADDR(BPHY)) uut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   function automatic logic [15:0] exp_lpa(input logic [15:0] adv);
      return 16'h4000 | (adv & 16'h01E0);
   endfunction

   function automatic logic [15:0] exp_spd(input logic [15:0] adv);
      logic [15:0] r = '0;
      r[10] = adv[7] | adv[8];
      r[11] = adv[8] | adv[6];
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic hwr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hrd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic issue(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg);
      hwr(A_CTRL, {3'b0, phy, 3'b0, rg, op, 2'b0, 1'b1, 11'b0});
      @(negedge clk);
   endtask

   task automatic phy_rd(input logic [4:0] phy, input logic [4:0] rg, output logic [31:0] v);
      issue(2'd2, phy, rg);
      hrd(A_RXD, v);
   endtask

   task automatic phy_wr(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] v);
      hwr(A_TXD, {16'h0, v});
      issue(2'd1, phy, rg);
   endtask

   task automatic adv_case(input logic [15:0] adv);
      logic [31:0] v;
      phy_wr(BPHY, 5'd4, adv);
      phy_rd(BPHY, 5'd4, v);
      check(v == {16'h0, adv}, "R2 adv readback", v, {16'h0, adv});
      phy_rd(BPHY, 5'd5, v);
      check(v == {16'h0, exp_lpa(adv)}, "R9 link partner", v, {16'h0, exp_lpa(adv)});
      phy_rd(BPHY, 5'(SPD), v);
      check(v == {16'h0, exp_spd(adv)}, "R10 speed/duplex", v, {16'h0, exp_spd(adv)});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      logic [15:0] keep;
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd1234);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      hrd(A_STAT, v);
      check(v == 32'h0, "R11 status after reset", v, 32'h0);
      hrd(A_CTRL, v);
      check(v == 32'h80, "R6 ctrl after reset", v, 32'h80);

      hwr(A_CFG, 32'h45);
      phy_rd(BPHY, 5'd0, v);  check(v == 32'h3100, "R1 reg0", v, 32'h3100);
      phy_rd(BPHY, 5'd2, v);  check(v == 32'h0300, "R1 reg2", v, 32'h0300);
      phy_rd(BPHY, 5'd3, v);  check(v == 32'hE400, "R1 reg3", v, 32'hE400);
      phy_rd(BPHY, 5'd4, v);  check(v == 32'h01E1, "R1 reg4", v, 32'h01E1);
      phy_rd(BPHY, 5'(SPD), v);
      check(v == {16'h0, exp_spd(16'h01E1)}, "R10 speed at reset", v, {16'h0, exp_spd(16'h01E1)});

      // R8: fixed status register
      phy_rd(BPHY, 5'd1, v);  check(v == 32'h782E, "R8 reg1", v, 32'h782E);
      phy_wr(BPHY, 5'd1, 16'h0000);
      phy_rd(BPHY, 5'd1, v);  check(v == 32'h782E, "R8 reg1 after write", v, 32'h782E);

      // R11: completion flag and clear
      hrd(A_STAT, v);  check(v[0] == 1'b1, "R11 done set", v, 32'h1);
      hwr(A_STAT, 32'h7);
      hrd(A_STAT, v);  check(v == 32'h0, "R11 done cleared", v, 32'h0);

      // R9 R10 directed advertisement words
      adv_case(16'h0000);
      adv_case(16'h0020);
      adv_case(16'h0040);
      adv_case(16'h0080);
      adv_case(16'h0100);
      adv_case(16'hFE1F);
      // R9 R10 random advertisement words
      for (int i = 0; i < 20; i++) adv_case(16'($urandom));

      // R2 R3: plain register write and read, upper half zero
      for (int i = 0; i < 8; i++) begin
         logic [15:0] d = 16'($urandom);
         logic [4:0]  rg = 5'(8 + (i % 8));
         phy_wr(BPHY, rg, d);
         phy_rd(BPHY, rg, v);
         check(v == {16'h0, d}, "R3 read back", v, {16'h0, d});
      end

      // R7: foreign address
      phy_wr(BPHY, 5'd4, 16'h0061);
      phy_wr(OTHER, 5'd4, 16'h0180);
      phy_rd(BPHY, 5'd4, v);
      check(v == 32'h0061, "R7 foreign write ignored", v, 32'h0061);
      phy_rd(OTHER, 5'd4, v);
      check(v == 32'hFFFF, "R7 foreign read", v, 32'hFFFF);

      // R4: invalid operations
      keep = 16'h5A5A;
      phy_wr(BPHY, 5'd10, keep);
      phy_rd(BPHY, 5'd0, v);
      hwr(A_STAT, 32'h7);
      hwr(A_TXD, 32'h1111);
      issue(2'd0, BPHY, 5'd10);
      hrd(A_STAT, v);
      check(v == 32'h2, "R4 op0 flagged", v, 32'h2);
      issue(2'd3, BPHY, 5'd10);
      hrd(A_RXD, v);
      check(v == 32'h3100, "R4 rxd unchanged", v, 32'h3100);
      phy_rd(BPHY, 5'd10, v);
      check(v == {16'h0, keep}, "R4 no write", v, {16'h0, keep});

      // R5: disabled and zero divider
      hwr(A_STAT, 32'h7);
      hwr(A_CFG, 32'h05);
      hwr(A_TXD, 32'h2222);
      issue(2'd1, BPHY, 5'd10);
      hrd(A_STAT, v);
      check(v == 32'h0, "R5 disabled quiet", v, 32'h0);
      hwr(A_CFG, 32'h40);
      issue(2'd1, BPHY, 5'd10);
      hrd(A_STAT, v);
      check(v == 32'h4, "R5 zero divider", v, 32'h4);
      hwr(A_CFG, 32'h41);
      phy_rd(BPHY, 5'd10, v);
      check(v == {16'h0, keep}, "R5 no write", v, {16'h0, keep});

      // R6: control word readback without initiate
      hwr(A_CTRL, 32'h0F0F_0000);
      hrd(A_CTRL, v);
      check(v == 32'h0F0F_0080, "R6 ctrl readback", v, 32'h0F0F_0080);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule